// File: doc/BRIEF.md
# Sub-Block Priority Fill Scheduler

This block sits between a miss handling unit and a DRAM controller. It takes cache-line fill requests and splits each 64-byte line into four 16-byte sub-blocks. The sub-block that holds the word the processor is waiting for is tagged high priority, and the other three are tagged low. Sixteen bytes is the smallest request the memory accepts, so no sub-block is smaller than that. Up to four lines may be in flight at once. The block sends one sub-block request at a time over a valid/ready port. It matches each DRAM response by a tag made of the slot index and the sub-block index. It hands every sub-block back to the processor on its own as soon as the response arrives, together with the line address and the sub-block index.

A secondary miss names a line and a sub-block. If that line is already being filled and the named sub-block has not yet been sent to DRAM, its priority is raised to high. No second fill is started. The scheduler always sends high-priority sub-blocks before low-priority ones. Among high-priority candidates it takes the oldest line first. Low-priority sub-blocks then follow in line-age order, with the lowest index first within a line. A line slot is released only after all four of its sub-blocks have come back.

Top module: `subblk_fill_sched`

## Requirements
- R1: After reset, miss_ready is 1, dreq_valid is 0 and ret_valid is 0.
- R2: Each accepted miss produces exactly NSUB (4) DRAM requests, one per sub-block. Each has dreq_addr = {line, sub} (sub in bits [1:0]) and dreq_tag = {slot, sub} (slot in bits [3:2], sub in bits [1:0]).
- R3: The critical sub-block, given as an index on miss_crit, is the first request issued for its line. When the request port is idle, dreq_valid rises on the second rising edge after the miss is accepted.
- R4: All pending high-priority sub-blocks are issued before any low-priority one. High-priority sub-blocks go oldest line first. Low-priority ones then go in line-age order, lowest sub-block index first within a line.
- R5: A secondary miss to a sub-block of an outstanding line that has not yet been issued makes it high priority. A secondary miss to a line that is not outstanding, or to a sub-block already issued, has no effect and creates no extra request.
- R6: Up to NSLOT (4) lines may be outstanding. miss_ready is 0 while all slots are busy. A new line takes the lowest-numbered free slot.
- R7: A slot is freed on the rising edge after the one that takes its last response. It is never freed earlier.
- R8: While dreq_valid is 1 and dreq_ready is 0, dreq_tag and dreq_addr hold steady.
- R9: Each response drives, one rising edge later, ret_valid with the line address and sub-block index of its tag and the response data. Responses may come back in any order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | New line fill request |
| miss_ready | output | 1 | A line slot is free |
| miss_line | input | LINE_AW | Line address of the fill |
| miss_crit | input | log2(NSUB) | Index of the critical sub-block |
| sec_valid | input | 1 | Secondary miss strobe |
| sec_line | input | LINE_AW | Line address of the secondary miss |
| sec_sub | input | log2(NSUB) | Sub-block named by the secondary miss |
| dreq_valid | output | 1 | DRAM request valid |
| dreq_ready | input | 1 | DRAM controller accepts the request |
| dreq_addr | output | LINE_AW+log2(NSUB) | Sub-block address {line, sub} |
| dreq_tag | output | log2(NSLOT)+log2(NSUB) | Request tag {slot, sub} |
| dresp_valid | input | 1 | DRAM response valid |
| dresp_tag | input | log2(NSLOT)+log2(NSUB) | Tag of the response |
| dresp_data | input | 128 | Sub-block data (16 bytes) |
| ret_valid | output | 1 | Sub-block returned to the processor |
| ret_line | output | LINE_AW | Line address of the returned sub-block |
| ret_sub | output | log2(NSUB) | Index of the returned sub-block |
| ret_data | output | 128 | Returned data |

## Verification
The bench builds the block with NSLOT=4 and NSUB=4 and narrows LINE_AW to 8 bits. This makes every slot and every sub-block index reachable in short runs. It sweeps each of the four critical positions on an empty scheduler. It then fills three slots behind a stalled request port and raises one low sub-block with a secondary miss, so that the whole high-then-low, oldest-first order can be compared with a list computed in the bench. Finally it fills all four slots to reach the full-stall and slot-release edges, and it returns responses in a permuted order.

// File: rtl/subblk_fill_sched.sv
module subblk_fill_sched #(
  parameter int LINE_AW = 26,
  parameter int NSLOT   = 4,
  parameter int NSUB    = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   miss_valid,
  output logic                                   miss_ready,
  input  logic [LINE_AW-1:0]                     miss_line,
  input  logic [$clog2(NSUB)-1:0]                miss_crit,
  input  logic                                   sec_valid,
  input  logic [LINE_AW-1:0]                     sec_line,
  input  logic [$clog2(NSUB)-1:0]                sec_sub,
  output logic                                   dreq_valid,
  input  logic                                   dreq_ready,
  output logic [LINE_AW+$clog2(NSUB)-1:0]        dreq_addr,
  output logic [$clog2(NSLOT)+$clog2(NSUB)-1:0]  dreq_tag,
  input  logic                                   dresp_valid,
  input  logic [$clog2(NSLOT)+$clog2(NSUB)-1:0]  dresp_tag,
  input  logic [127:0]                           dresp_data,
  output logic                                   ret_valid,
  output logic [LINE_AW-1:0]                     ret_line,
  output logic [$clog2(NSUB)-1:0]                ret_sub,
  output logic [127:0]                           ret_data
);
  localparam int SUB_W  = $clog2(NSUB);
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int TAG_W  = SLOT_W + SUB_W;

  logic [NSLOT-1:0]   vld_q;
  logic [LINE_AW-1:0] line_q  [NSLOT];
  logic [NSUB-1:0]    need_q  [NSLOT];
  logic [NSUB-1:0]    hi_q    [NSLOT];
  logic [NSUB-1:0]    wait_q  [NSLOT];
  logic [NSLOT-1:0]   older_q [NSLOT];   // older_q[i][j]: slot i allocated before slot j

  logic              rq_v;
  logic [SLOT_W-1:0] rq_slot;
  logic [SUB_W-1:0]  rq_sub;

  logic [SLOT_W-1:0] alloc_slot;
  logic              alloc;
  logic [NSLOT-1:0]  sec_hit;
  logic [NSLOT-1:0]  cand_hi, cand_lo, cand;
  logic              pick_v, pick_hi, load;
  logic [SLOT_W-1:0] pick_slot;
  logic [SUB_W-1:0]  pick_sub;
  logic [NSUB-1:0]   pick_mask;
  logic [SLOT_W-1:0] rsp_slot;
  logic [SUB_W-1:0]  rsp_sub;

  assign miss_ready = ~&vld_q;
  assign alloc      = miss_valid && miss_ready;
  assign load       = !rq_v || dreq_ready;
  assign rsp_slot   = dresp_tag[TAG_W-1:SUB_W];
  assign rsp_sub    = dresp_tag[SUB_W-1:0];

  assign dreq_valid = rq_v;
  assign dreq_tag   = {rq_slot, rq_sub};
  assign dreq_addr  = {line_q[rq_slot], rq_sub};

  always_comb begin
    alloc_slot = '0;
    for (int s = NSLOT-1; s >= 0; s--)
      if (!vld_q[s]) alloc_slot = SLOT_W'(s);
    for (int s = 0; s < NSLOT; s++)
      sec_hit[s] = vld_q[s] && (line_q[s] == sec_line);
  end

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      cand_hi[s] = vld_q[s] && |(need_q[s] & hi_q[s]);
      cand_lo[s] = vld_q[s] && |need_q[s];
    end
    pick_hi = |cand_hi;
    cand    = pick_hi ? cand_hi : cand_lo;
    pick_v  = |cand;
    pick_slot = '0;
    for (int s = 0; s < NSLOT; s++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < NSLOT; j++)
        if (cand[j] && older_q[j][s]) blocked = 1'b1;
      if (cand[s] && !blocked) pick_slot = SLOT_W'(s);
    end
    pick_mask = pick_hi ? (need_q[pick_slot] & hi_q[pick_slot]) : need_q[pick_slot];
    pick_sub  = '0;
    for (int b = NSUB-1; b >= 0; b--)
      if (pick_mask[b]) pick_sub = SUB_W'(b);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= '0;
      rq_v      <= 1'b0;
      rq_slot   <= '0;
      rq_sub    <= '0;
      ret_valid <= 1'b0;
      ret_line  <= '0;
      ret_sub   <= '0;
      ret_data  <= '0;
      for (int s = 0; s < NSLOT; s++) begin
        line_q[s]  <= '0;
        need_q[s]  <= '0;
        hi_q[s]    <= '0;
        wait_q[s]  <= '0;
        older_q[s] <= '0;
      end
    end else begin
      ret_valid <= dresp_valid;
      if (dresp_valid) begin
        ret_line <= line_q[rsp_slot];
        ret_sub  <= rsp_sub;
        ret_data <= dresp_data;
        wait_q[rsp_slot][rsp_sub] <= 1'b0;
      end
      if (load) begin
        rq_v <= pick_v;
        if (pick_v) begin
          rq_slot <= pick_slot;
          rq_sub  <= pick_sub;
          need_q[pick_slot][pick_sub] <= 1'b0;
          wait_q[pick_slot][pick_sub] <= 1'b1;
        end
      end
      for (int s = 0; s < NSLOT; s++) begin
        if (sec_valid && sec_hit[s] && need_q[s][sec_sub]) hi_q[s][sec_sub] <= 1'b1;
        if (vld_q[s] && need_q[s] == '0 && wait_q[s] == '0) vld_q[s] <= 1'b0;
      end
      if (alloc) begin
        vld_q[alloc_slot]  <= 1'b1;
        line_q[alloc_slot] <= miss_line;
        need_q[alloc_slot] <= '1;
        hi_q[alloc_slot]   <= NSUB'(1) << miss_crit;
        wait_q[alloc_slot] <= '0;
        for (int j = 0; j < NSLOT; j++) older_q[j][alloc_slot] <= vld_q[j];
        older_q[alloc_slot] <= '0;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_valid && !dreq_ready |=> dreq_valid && $stable(dreq_tag) && $stable(dreq_addr)); // R8

  AST_RSP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dresp_valid |-> wait_q[rsp_slot][rsp_sub]); // R9

  AST_RET_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    dresp_valid |=> ret_valid && ret_sub == $past(rsp_sub)); // R9

  AST_NO_ALLOC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    &vld_q |=> (vld_q & ~$past(vld_q)) == '0); // R6

  AST_ONE_HIGH_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> $countones(hi_q[$past(alloc_slot)]) == 1); // R3

  for (genvar g = 0; g < NSLOT; g++) begin : g_free_chk
    AST_FREE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vld_q[g]) |-> $past(need_q[g] == '0 && wait_q[g] == '0)); // R7
  end
endmodule

// File: tb/tb_subblk_fill_sched.sv
module tb_subblk_fill_sched;
  localparam int LAW = 8;

  logic clk = 0, rst_n = 0;
  logic miss_valid = 0, sec_valid = 0, dreq_ready = 0, dresp_valid = 0;
  logic miss_ready, dreq_valid, ret_valid;
  logic [LAW-1:0] miss_line = 0, sec_line = 0, ret_line;
  logic [1:0] miss_crit = 0, sec_sub = 0, ret_sub;
  logic [LAW+1:0] dreq_addr;
  logic [3:0] dreq_tag, dresp_tag = 0;
  logic [127:0] dresp_data = 0, ret_data;

  int checks = 0, fails = 0, n_iss = 0;
  logic [3:0]     iss_tag  [64];
  logic [LAW+1:0] iss_addr [64];
  logic [3:0]     exp_tag  [16];

  always #4 clk = ~clk;

  subblk_fill_sched #(.LINE_AW(LAW), .NSLOT(4), .NSUB(4)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_miss(input logic [LAW-1:0] l, input logic [1:0] c);
    bit ok;
    miss_valid = 1; miss_line = l; miss_crit = c;
    do begin ok = miss_ready; @(negedge clk); end while (!ok);
    miss_valid = 0;
  endtask

  task automatic send_sec(input logic [LAW-1:0] l, input logic [1:0] b);
    sec_valid = 1; sec_line = l; sec_sub = b;
    @(negedge clk);
    sec_valid = 0;
  endtask

  task automatic collect(input int n);
    int got = 0;
    while (got < n) begin
      if (dreq_valid && dreq_ready) begin
        iss_tag[n_iss] = dreq_tag; iss_addr[n_iss] = dreq_addr;
        n_iss++; got++;
      end
      @(negedge clk);
    end
  endtask

  task automatic respond(input int k);
    logic [127:0] d;
    d = {32'(iss_addr[k]), 32'(iss_tag[k]), 32'hC0FFEE00 ^ 32'(k), 32'(k)};
    dresp_valid = 1; dresp_tag = iss_tag[k]; dresp_data = d;
    @(negedge clk);
    dresp_valid = 0;
    chk(ret_valid == 1, "R9", "ret_valid", 128'(ret_valid), 1);
    chk(ret_line == iss_addr[k][LAW+1:2], "R9", "ret_line", 128'(ret_line), 128'(iss_addr[k][LAW+1:2]));
    chk(ret_sub == iss_tag[k][1:0], "R9", "ret_sub", 128'(ret_sub), 128'(iss_tag[k][1:0]));
    chk(ret_data == d, "R9", "ret_data", ret_data, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(miss_ready == 1, "R1", "miss_ready", 128'(miss_ready), 1);
    chk(dreq_valid == 0, "R1", "dreq_valid", 128'(dreq_valid), 0);
    chk(ret_valid == 0, "R1", "ret_valid", 128'(ret_valid), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 / R3: every critical position on an empty scheduler
    for (int c = 0; c < 4; c++) begin
      logic [LAW-1:0] l;
      l = LAW'(8'h10 + c);
      n_iss = 0; dreq_ready = 1;
      send_miss(l, 2'(c));
      chk(dreq_valid == 0, "R3", "dreq_valid one cycle after accept", 128'(dreq_valid), 0);
      collect(4);
      chk(iss_tag[0] == {2'd0, 2'(c)}, "R3", "first tag", 128'(iss_tag[0]), 128'({2'd0, 2'(c)}));
      for (int k = 1; k < 4; k++) begin
        int sb;
        sb = (k - 1 < c) ? k - 1 : k;
        chk(iss_tag[k] == {2'd0, 2'(sb)}, "R2", "tag", 128'(iss_tag[k]), 128'({2'd0, 2'(sb)}));
        chk(iss_addr[k] == {l, 2'(sb)}, "R2", "addr", 128'(iss_addr[k]), 128'({l, 2'(sb)}));
      end
      @(negedge clk);
      chk(dreq_valid == 0, "R2", "no fifth request", 128'(dreq_valid), 0);
      for (int k = 3; k >= 0; k--) respond(k);
      @(negedge clk); @(negedge clk);
      chk(miss_ready == 1, "R7", "slot free after drain", 128'(miss_ready), 1);
    end

    // R4 / R5 / R8: three lines behind a stalled port
    n_iss = 0; dreq_ready = 0;
    send_miss(8'h20, 2);
    send_miss(8'h21, 1);
    send_miss(8'h22, 3);
    send_sec(8'h20, 0);
    send_sec(8'h55, 1);
    send_sec(8'h20, 2);
    chk(dreq_valid == 1 && dreq_tag == 4'b0010, "R8", "held tag", 128'(dreq_tag), 4'b0010);
    repeat (3) @(negedge clk);
    chk(dreq_tag == 4'b0010 && dreq_addr == {8'h20, 2'd2}, "R8", "held after stall", 128'(dreq_tag), 4'b0010);
    begin
      int crit[3] = '{2, 1, 3};
      int e = 0;
      exp_tag[e++] = 4'b0010;
      for (int ln = 0; ln < 3; ln++)
        for (int b = 0; b < 4; b++)
          if ((ln != 0 && b == crit[ln]) || (ln == 0 && b == 0)) exp_tag[e++] = {2'(ln), 2'(b)};
      for (int ln = 0; ln < 3; ln++)
        for (int b = 0; b < 4; b++)
          if (b != crit[ln] && !(ln == 0 && b == 0)) exp_tag[e++] = {2'(ln), 2'(b)};
    end
    dreq_ready = 1;
    collect(12);
    for (int k = 0; k < 12; k++) begin
      chk(iss_tag[k] == exp_tag[k], "R4", "issue order", 128'(iss_tag[k]), 128'(exp_tag[k]));
      chk(iss_addr[k][LAW+1:2] == LAW'(8'h20 + iss_tag[k][3:2]), "R2", "line of addr",
          128'(iss_addr[k]), 128'(8'h20 + iss_tag[k][3:2]));
    end
    @(negedge clk); @(negedge clk);
    chk(dreq_valid == 0, "R5", "no extra request from secondary", 128'(dreq_valid), 0);
    for (int k = 0; k < 12; k++) respond((k * 5) % 12);
    @(negedge clk); @(negedge clk);

    // R6 / R7: all slots busy
    n_iss = 0; dreq_ready = 0;
    for (int i = 0; i < 4; i++) send_miss(LAW'(8'h30 + i), 0);
    chk(miss_ready == 0, "R6", "full stall", 128'(miss_ready), 0);
    miss_valid = 1; miss_line = 8'h40; miss_crit = 1;
    repeat (3) @(negedge clk);
    chk(miss_ready == 0, "R6", "still full", 128'(miss_ready), 0);
    miss_valid = 0;
    dreq_ready = 1;
    collect(16);
    for (int i = 0; i < 4; i++)
      chk(iss_tag[i] == {2'(i), 2'd0} && iss_addr[i] == {LAW'(8'h30 + i), 2'd0}, "R6",
          "slot per line", 128'(iss_tag[i]), 128'({2'(i), 2'd0}));
    for (int k = 0; k < 16; k++) if (iss_tag[k][3:2] == 2) respond(k);
    chk(miss_ready == 0, "R7", "not free on last response edge", 128'(miss_ready), 0);
    @(negedge clk);
    chk(miss_ready == 1, "R7", "free one edge later", 128'(miss_ready), 1);
    send_miss(8'h40, 1);
    collect(1);
    chk(iss_tag[16] == 4'b1001, "R6", "lowest free slot reused", 128'(iss_tag[16]), 4'b1001);
    collect(3);
    for (int k = 0; k < 20; k++) if (iss_tag[k][3:2] != 2 || k >= 16) respond(k);
    @(negedge clk); @(negedge clk);
    chk(miss_ready == 1 && dreq_valid == 0, "R7", "idle at end", 128'(dreq_valid), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule